// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is an 8-bit up/down counter that drives one centre-aligned PWM output. A free-running prescaler turns the system clock into a timer tick at one of five division ratios. On each tick the counter moves one step, climbing from zero to its top value and then descending back to zero. Because it turns around at the top, every period is symmetric about the top of the count.

A compare value is matched against the counter on both slopes. In the non-inverting mode, a match on the rising slope drives the output low and a match on the falling slope drives it high. The inverting mode swaps these two actions. Software writes the compare value into a holding register. That value reaches the comparator only when the counter sits at its top value, so a new duty cycle always starts on a period boundary. The block also keeps two sticky flags, one for the bottom of the count and one for a compare hit. Writing a one to the matching clear bit resets each flag.

Top module: `pc_pwm_timer`

## Requirements
- R1: The counter starts at 0, advances only on a timer tick, and visits 0,1,…,255,254,…,1,0 without repeating either end value, so one period is 510 ticks.
- R2: The timer tick comes from a free-running 10-bit prescaler. The clock-select code picks the rate: 1 ticks every cycle, 2 ticks when the low 3 prescaler bits are all ones (÷8), 3 uses the low 6 bits (÷64), 4 the low 8 bits (÷256), 5 all 10 bits (÷1024). Codes 0, 6 and 7 give no ticks, so the counter and flags stay frozen.
- R3: A tick taken while the counter is 0 sets the overflow flag, which reads 1 from the next cycle on.
- R4: With mode code 2 (non-inverting), a tick at a count equal to the active compare value drives the output to 0 on the rising slope and to 1 on the falling slope. For a compare value k between 1 and 254, the output is therefore high for 2k of every 510 ticks.
- R5: With mode code 3 (inverting), the output is the complement of the mode-2 level, so it is high for 510−2k of every 510 ticks.
- R6: An active compare value of 0 holds the output at 0 in mode 2 and at 1 in mode 3. A value of 255 holds it at 1 in mode 2 and at 0 in mode 3. In both cases the level holds once the counter has passed through that value.
- R7: A compare write only fills the holding register. The active compare value takes the holding value on the tick at which the counter is 255, and at no other time.
- R8: A tick at which the counter equals the active compare value sets the compare flag, on either slope.
- R9: flag_clr bit 0 clears the overflow flag and bit 1 clears the compare flag, one cycle after the request. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R10: Mode codes 0 and 1 hold the output at 0. A mode write takes effect on the output from the next cycle.
- R11: Reset leaves the counter at 0 counting up, both compare registers at 0, the mode at 0, the flags at 0 and the output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Prescaler select code |
| cmp_we | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | 8 | Compare value to write |
| mode_we | input | 1 | Write strobe for the output mode |
| mode_wdata | input | 2 | Output mode code |
| flag_clr | input | 2 | Flag clear: bit 0 overflow, bit 1 compare |
| pwm_out | output | 1 | PWM waveform |
| ovf_flag | output | 1 | Sticky bottom-of-count flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
Each tick-driven result (output level, overflow flag, compare flag, counter step) appears in the cycle after the rising edge that takes the tick. A mode write or a flag clear shows one cycle after its strobe. A compare write shows no effect until the tick at count 255, and its first level change follows that tick. The bench drives inputs and samples outputs on the falling edge. Its model advances on the same rising edge as the design, so every comparison falls half a cycle after the edge where the result is due. Duty and period checks count falling edges over whole 510-tick windows, started only after the load at count 255 and a full settling period have both passed.

// File: rtl/pc_pwm_timer.sv
module pc_pwm_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    clk_sel,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          mode_we,
  input  logic [1:0]    mode_wdata,
  input  logic [1:0]    flag_clr,
  output logic          pwm_out,
  output logic          ovf_flag,
  output logic          cmp_flag
);

  localparam int            PSW = 10;
  localparam logic [CW-1:0] BOT = '0;
  localparam logic [CW-1:0] TOP = '1;

  logic [PSW-1:0] pre;
  logic           tick;
  logic [CW-1:0]  cnt;
  logic           up;
  logic [CW-1:0]  cmp_hold;
  logic [CW-1:0]  cmp_act;
  logic [1:0]     mode;
  logic           oc;
  logic           hit;

  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;
  end

  always_comb begin
    case (clk_sel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre[2:0];
      3'd3:    tick = &pre[5:0];
      3'd4:    tick = &pre[7:0];
      3'd5:    tick = &pre[9:0];
      default: tick = 1'b0;
    endcase
  end

  assign hit = tick && (cnt == cmp_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= BOT;
      up  <= 1'b1;
    end else if (tick) begin
      if (up) begin
        cnt <= cnt + 1'b1;
        if (cnt == TOP - 1'b1) up <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == BOT + 1'b1) up <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_hold <= '0;
      cmp_act  <= '0;
      mode     <= 2'd0;
    end else begin
      if (cmp_we)               cmp_hold <= cmp_wdata;
      if (tick && cnt == TOP)   cmp_act  <= cmp_hold;
      if (mode_we)              mode     <= mode_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oc <= 1'b0;
    end else if (hit) begin
      if (cmp_act == BOT)      oc <= 1'b0;
      else if (cmp_act == TOP) oc <= 1'b1;
      else                     oc <= ~up;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (tick && cnt == BOT) ovf_flag <= 1'b1;
      else if (flag_clr[0])   ovf_flag <= 1'b0;
      if (hit)                cmp_flag <= 1'b1;
      else if (flag_clr[1])   cmp_flag <= 1'b0;
    end
  end

  assign pwm_out = (mode == 2'd2) ? oc : (mode == 2'd3) ? ~oc : 1'b0;

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((cnt == CW'($past(cnt) + 1'b1)) || (cnt == CW'($past(cnt) - 1'b1))));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_turn_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == TOP) |=> (cnt == TOP - 1'b1));

  assert_turn_bot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == BOT) |=> (cnt == BOT + 1'b1));

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == BOT) |=> ovf_flag);

  assert_load_only_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && cnt == TOP) |=> $stable(cmp_act));

  assert_cmp_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == cmp_act) |=> cmp_flag);

  assert_low_extreme_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == BOT && cmp_act == BOT) |=> !oc);

endmodule

// File: tb/tb_pc_pwm_timer.sv
`timescale 1ns/1ps
module tb_pc_pwm_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] clk_sel;
  logic       cmp_we;
  logic [7:0] cmp_wdata;
  logic       mode_we;
  logic [1:0] mode_wdata;
  logic [1:0] flag_clr;
  logic       pwm_out, ovf_flag, cmp_flag;

  always #2.5 clk = ~clk;

  pc_pwm_timer dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .flag_clr(flag_clr),
    .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  int  total = 0;
  int  bad   = 0;
  int  cyc   = 0;
  bit  cmp_on = 1'b0;
  bit  done   = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      if (bad < 40) $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // reference model built from the requirements
  logic [9:0] m_pre;
  logic [7:0] m_cnt, m_hold, m_act;
  logic       m_up, m_oc, m_ovf, m_mf;
  logic [1:0] m_mode;

  function automatic bit f_tick(input logic [2:0] s, input logic [9:0] p);
    case (s)
      3'd1: return 1'b1;
      3'd2: return p[2:0] == 3'b111;
      3'd3: return p[5:0] == 6'h3f;
      3'd4: return p[7:0] == 8'hff;
      3'd5: return p == 10'h3ff;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic f_pwm(input logic [1:0] md, input logic lvl);
    if (md == 2'd2) return lvl;
    if (md == 2'd3) return !lvl;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_pre <= 0; m_cnt <= 0; m_up <= 1; m_hold <= 0; m_act <= 0;
      m_mode <= 0; m_oc <= 0; m_ovf <= 0; m_mf <= 0;
    end else begin
      m_pre <= m_pre + 1;
      if (cmp_we)  m_hold <= cmp_wdata;
      if (mode_we) m_mode <= mode_wdata;
      if (f_tick(clk_sel, m_pre)) begin
        if (m_cnt == 8'd255) begin
          m_act <= m_hold; m_cnt <= 8'd254; m_up <= 0;
        end else if (m_cnt == 8'd0) begin
          m_cnt <= 8'd1; m_up <= 1;
        end else begin
          m_cnt <= m_up ? m_cnt + 1 : m_cnt - 1;
        end
        if (m_cnt == m_act) begin
          m_oc <= (m_act == 0) ? 1'b0 : (m_act == 8'd255) ? 1'b1 : !m_up;
          m_mf <= 1;
        end else if (flag_clr[1]) m_mf <= 0;
        if (m_cnt == 0) m_ovf <= 1;
        else if (flag_clr[0]) m_ovf <= 0;
      end else begin
        if (flag_clr[1]) m_mf <= 0;
        if (flag_clr[0]) m_ovf <= 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(pwm_out === f_pwm(m_mode, m_oc),
          (m_mode == 3) ? "R5 model" : (m_mode == 2) ? "R4 model" : "R10 model",
          pwm_out, f_pwm(m_mode, m_oc));
      chk(ovf_flag === m_ovf, "R3 model", ovf_flag, m_ovf);
      chk(cmp_flag === m_mf, "R8 model", cmp_flag, m_mf);
    end
  end

  task automatic wr_cmp(input logic [7:0] v);
    @(negedge clk); cmp_we = 1; cmp_wdata = v;
    @(negedge clk); cmp_we = 0;
  endtask

  task automatic wr_mode(input logic [1:0] v);
    @(negedge clk); mode_we = 1; mode_wdata = v;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic clr(input logic [1:0] v);
    @(negedge clk); flag_clr = v;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic wait_cnt(input int v, input bit u);
    do @(negedge clk); while (!(m_cnt == v && m_up == u));
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  task automatic ovf_interval(output int d);
    int t1;
    clr(2'b01);
    do @(negedge clk); while (!ovf_flag);
    t1 = cyc;
    clr(2'b01);
    do @(negedge clk); while (!ovf_flag);
    d = cyc - t1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int h, d;
    void'($urandom(32'd4242));
    rst_n = 0; clk_sel = 0; cmp_we = 0; cmp_wdata = 0;
    mode_we = 0; mode_wdata = 0; flag_clr = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(pwm_out == 0, "R11 pwm", pwm_out, 0);
    chk(ovf_flag == 0, "R11 ovf", ovf_flag, 0);
    chk(cmp_flag == 0, "R11 cmp", cmp_flag, 0);
    rst_n = 1;
    cmp_on = 1;

    // R2: stopped select gives no tick, so count 0 never raises the flag
    repeat (50) @(negedge clk);
    chk(ovf_flag == 0, "R2 stopped", ovf_flag, 0);
    clk_sel = 3'd7;
    repeat (50) @(negedge clk);
    chk(ovf_flag == 0, "R2 stopped code7", ovf_flag, 0);

    // R4 / R5: duty for k=100
    clk_sel = 3'd1;
    wr_mode(2);
    wr_cmp(100);
    repeat (1100) @(negedge clk);
    count_high(510, h);
    chk(h == 200, "R4 duty k=100", h, 200);
    wr_mode(3);
    count_high(510, h);
    chk(h == 310, "R5 duty k=100", h, 310);
    wr_mode(2);

    // R1 / R2: period length
    ovf_interval(d);
    chk(d == 510, "R1 period div1", d, 510);
    clk_sel = 3'd2;
    ovf_interval(d);
    chk(d == 4080, "R2 period div8", d, 4080);
    clk_sel = 3'd1;

    // R7: buffered compare load
    wait_cnt(50, 1);
    wr_cmp(200);
    wait_cnt(150, 1);
    chk(pwm_out == 0, "R7 old value still active", pwm_out, 0);
    wait_cnt(150, 0);
    chk(pwm_out == 1, "R7 new value after top", pwm_out, 1);

    // R8 / R9: compare flag set, clear, priority
    clr(2'b10);
    chk(cmp_flag == 0, "R9 cmp clear", cmp_flag, 0);
    wait_cnt(199, 1);
    chk(cmp_flag == 0, "R8 before hit", cmp_flag, 0);
    @(negedge clk); @(negedge clk);
    chk(cmp_flag == 1, "R8 up-slope hit", cmp_flag, 1);
    clr(2'b10);
    wait_cnt(200, 0);
    flag_clr = 2'b10;
    @(negedge clk);
    flag_clr = 0;
    chk(cmp_flag == 1, "R9 set beats clear", cmp_flag, 1);
    clr(2'b01);
    chk(ovf_flag == 0, "R9 ovf clear", ovf_flag, 0);

    // R6: extremes
    wr_cmp(0);
    repeat (1100) @(negedge clk);
    count_high(1020, h);
    chk(h == 0, "R6 k=0 mode2", h, 0);
    wr_mode(3);
    count_high(1020, h);
    chk(h == 1020, "R6 k=0 mode3", h, 1020);
    wr_mode(2);
    wr_cmp(255);
    repeat (1100) @(negedge clk);
    count_high(1020, h);
    chk(h == 1020, "R6 k=255 mode2", h, 1020);
    wr_mode(3);
    count_high(1020, h);
    chk(h == 0, "R6 k=255 mode3", h, 0);

    // R10: disconnected modes
    wr_cmp(100);
    wr_mode(0);
    count_high(600, h);
    chk(h == 0, "R10 mode0", h, 0);
    wr_mode(1);
    count_high(600, h);
    chk(h == 0, "R10 mode1", h, 0);

    // random mix checked against the model
    for (int s = 0; s < 40; s++) begin
      int n;
      wr_cmp(8'($urandom));
      wr_mode(2'($urandom));
      case ($urandom % 5)
        0: clk_sel = 3'd0;
        1: clk_sel = 3'd2;
        2: clk_sel = 3'd3;
        default: clk_sel = 3'd1;
      endcase
      n = 300 + int'($urandom % 600);
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        flag_clr = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
      end
      flag_clr = 0;
    end

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule